// File: doc/BRIEF.md
# Prioritized Three-Source Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core. It serves three sources: one external line and two timer-overflow lines. Raw request pulses are gathered between phase strobes. At each strobe they are transferred into sticky request flags, which are held in a single 8-bit control/status register together with the enable bits. Software reads and writes that register through a plain register port.

The block raises an interrupt request to the core while the master enable is on and at least one flag has its own enable set. When the core signals acceptance, the block selects the enabled flag with the highest priority. On the next cycle it shows that source's vector address and gives a one-cycle acknowledge pulse. In the same step it clears the serviced flag and the master enable, so a second interrupt cannot nest until software turns the master enable back on.

Top module: `intc_top`

## Requirements
- R1: The register reads as: bit 0 master enable, bit 1 external enable, bit 2 timer-0 enable, bit 3 timer-1 enable, bit 4 external flag, bit 5 timer-0 flag, bit 6 timer-1 flag. Bit 7 always reads 0. A write loads bits 0 to 6.
- R2: A raw request (reqRaw bit 0 external, bit 1 timer 0, bit 2 timer 1) seen in any cycle since the previous strobe, or in the strobe cycle itself, sets its flag at the end of the strobe cycle. With no strobe, no flag is set by hardware.
- R3: A flag stays set until it is serviced or software writes 0 to it. Flags are set whether or not their enable is on.
- R4: When a hardware flag set and a software write of 0 to that flag happen in the same cycle, the flag ends up set.
- R5: intReq is high exactly when the master enable is 1 and some flag has its matching enable set. With the master enable at 0, intReq stays low.
- R6: On acceptance the serviced source is the highest-priority one among the enabled set flags, in the order external, then timer 0, then timer 1. Their vectors are 0x04, 0x08 and 0x0C.
- R7: intAck sampled high while intReq is high produces, on the next cycle, ackPulse high for exactly one cycle and vecOut equal to the vector. The serviced flag is cleared and the master enable is cleared; this clear wins over a write in the same cycle.
- R8: intAck while intReq is low has no effect: there is no pulse, vecOut is unchanged and the register is unchanged.
- R9: After reset the register reads 0x00, intReq and ackPulse are low, and vecOut is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data |
| reqRaw | input | 3 | Raw request pulses: external, timer 0, timer 1 |
| phaseStb | input | 1 | Phase strobe that samples requests into flags |
| intAck | input | 1 | Core accepts the pending interrupt |
| intReq | output | 1 | Interrupt request to the core |
| ackPulse | output | 1 | One-cycle acknowledge of an accepted interrupt |
| vecOut | output | 8 | Vector address of the last serviced source |

## Verification
The hardest situations to reach are the collisions within a single cycle. One is a strobe that sets a flag in the same cycle software writes it to 0. Another is an acceptance that clears a flag while the strobe sets it again. A third is a write that turns the master enable on in the cycle it is being cleared by an acceptance. The bench drives these collisions directly with scripted steps. It then runs a long stretch of random writes, strobes, requests and acknowledges, with a behavioural model compared on every cycle, so that the collisions also occur in mixed orders.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_SRC = 3;
  localparam int REG_W   = 8;

  typedef struct packed {
    logic               wrEn;
    logic [NUM_SRC-1:0] setMask;
    logic [NUM_SRC-1:0] clrMask;
    logic               clrGie;
  } ctlStrb_t;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  parameter int RW   = REG_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrb_t        strb,
  input  logic [RW-1:0]   wrData,
  output logic            gie,
  output logic [NSRC-1:0] enMask,
  output logic [NSRC-1:0] flagMask,
  output logic [RW-1:0]   rdData
);
  localparam int EN_LO = 1;
  localparam int FL_LO = EN_LO + NSRC;
  localparam int USED  = FL_LO + NSRC;

  logic [NSRC-1:0] flagBase;

  always_comb begin
    flagBase = strb.wrEn ? wrData[FL_LO +: NSRC] : flagMask;
    flagBase = flagBase & ~strb.clrMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gie      <= 1'b0;
      enMask   <= '0;
      flagMask <= '0;
    end else begin
      if (strb.clrGie)    gie <= 1'b0;
      else if (strb.wrEn) gie <= wrData[0];
      if (strb.wrEn) enMask <= wrData[EN_LO +: NSRC];
      // hardware set applied last: wins over clear and write
      flagMask <= flagBase | strb.setMask;
    end
  end

  always_comb begin
    rdData = '0;
    rdData[0] = gie;
    rdData[EN_LO +: NSRC] = enMask;
    rdData[FL_LO +: NSRC] = flagMask;
  end

  // R4: a set bit requested by hardware is present one cycle later
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    strb.setMask[0] |=> flagMask[0]);
  // R1: bits above the layout never read as 1
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdData[RW-1:USED] == '0);
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int NSRC     = NUM_SRC,
  parameter int VW       = REG_W,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] reqRaw,
  input  logic            phaseStb,
  input  logic            regWe,
  input  logic            intAck,
  input  logic            gie,
  input  logic [NSRC-1:0] enMask,
  input  logic [NSRC-1:0] flagMask,
  output ctlStrb_t        strb,
  output logic            intReq,
  output logic            ackPulse,
  output logic [VW-1:0]   vecOut
);
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0] pendMask;
  logic [NSRC-1:0] liveMask;
  logic [IDX_W-1:0] selIdx;
  logic            accept;

  assign liveMask = flagMask & enMask;
  assign intReq   = gie && (|liveMask);
  assign accept   = intAck && intReq;

  always_comb begin
    selIdx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (liveMask[i]) selIdx = IDX_W'(i);
  end

  always_comb begin
    strb         = '0;
    strb.wrEn    = regWe;
    strb.setMask = phaseStb ? (pendMask | reqRaw) : '0;
    if (accept) begin
      strb.clrMask[selIdx] = 1'b1;
      strb.clrGie          = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendMask <= '0;
      ackPulse <= 1'b0;
      vecOut   <= '0;
    end else begin
      pendMask <= phaseStb ? '0 : (pendMask | reqRaw);
      ackPulse <= accept;
      if (accept) vecOut <= VW'(VEC_BASE + VEC_STEP * int'(selIdx));
    end
  end

  // R5: request only with master enable
  a_r5_req_needs_gie: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> gie);
  // R7: acceptance drops the master enable
  a_r7_gie_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intReq) |=> !gie);
  // R7: acknowledge is a single cycle
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |=> !ackPulse);
  // R8: no pulse without a pending request
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !(intAck && intReq) |=> !ackPulse);
  // R2: a flag appears only after a strobe or a write
  a_r2_flag_source: assert property (@(posedge clk) disable iff (!rstN)
    (!phaseStb && !regWe && !flagMask[0]) |=> !flagMask[0]);
  // R6: vector always one of the source slots
  a_r6_vec_range: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> (vecOut == VW'(VEC_BASE) || vecOut == VW'(VEC_BASE + VEC_STEP)
                  || vecOut == VW'(VEC_BASE + 2 * VEC_STEP)));
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWe,
  input  logic [7:0]   regWdata,
  output logic [7:0]   regRdata,
  input  logic [2:0]   reqRaw,
  input  logic         phaseStb,
  input  logic         intAck,
  output logic         intReq,
  output logic         ackPulse,
  output logic [7:0]   vecOut
);
  ctlStrb_t           strb;
  logic               gie;
  logic [NUM_SRC-1:0] enMask;
  logic [NUM_SRC-1:0] flagMask;

  intc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqRaw(reqRaw), .phaseStb(phaseStb),
    .regWe(regWe), .intAck(intAck), .gie(gie), .enMask(enMask),
    .flagMask(flagMask), .strb(strb), .intReq(intReq),
    .ackPulse(ackPulse), .vecOut(vecOut)
  );

  intc_regs u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWdata),
    .gie(gie), .enMask(enMask), .flagMask(flagMask), .rdData(regRdata)
  );
endmodule

// File: tb/sim_intc_top.sv
`timescale 1ns/1ps
module sim_intc_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic [2:0] reqRaw = '0;
  logic       phaseStb = 1'b0;
  logic       intAck = 1'b0;
  logic       intReq;
  logic       ackPulse;
  logic [7:0] vecOut;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  int mPend = 0, mFlag = 0, mEn = 0, mGie = 0, mVec = 0, mAck = 0;

  always #4 clk = ~clk;

  intc_top u0 (.*);

  function automatic int mReq();
    return (mGie != 0 && (mFlag & mEn) != 0) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    int nF, nE, nG, sel, setM;
    if (!rstN) begin
      mPend = 0; mFlag = 0; mEn = 0; mGie = 0; mVec = 0; mAck = 0;
    end else begin
      nF = regWe ? int'(regWdata[6:4]) : mFlag;
      nE = regWe ? int'(regWdata[3:1]) : mEn;
      nG = regWe ? int'(regWdata[0])   : mGie;
      mAck = 0;
      if (intAck && mReq() == 1) begin
        sel = 0;
        while (((mFlag & mEn) & (1 << sel)) == 0) sel++;
        nF = nF & ~(1 << sel);
        nG = 0;
        mVec = 4 + 4 * sel;
        mAck = 1;
      end
      setM = phaseStb ? (mPend | int'(reqRaw)) : 0;
      mPend = phaseStb ? 0 : (mPend | int'(reqRaw));
      mFlag = nF | setM;
      mEn = nE;
      mGie = nG;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R1 regRdata", int'(regRdata), mFlag * 16 + mEn * 2 + mGie);
      chk("R5 intReq", int'(intReq), mReq());
      chk("R7 ackPulse", int'(ackPulse), mAck);
      chk("R6 vecOut", int'(vecOut), mVec);
    end
  end

  task automatic step(bit we = 0, logic [7:0] wd = 0, logic [2:0] rq = 0,
                      bit stb = 0, bit ack = 0);
    @(negedge clk);
    regWe = we; regWdata = wd; reqRaw = rq; phaseStb = stb; intAck = ack;
    @(negedge clk);
    regWe = 0; reqRaw = 0; phaseStb = 0; intAck = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        finishRun();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R9 reset state
    chk("R9 reset reg", int'(regRdata), 0);
    chk("R9 reset intReq", int'(intReq), 0);
    chk("R9 reset vec", int'(vecOut), 0);
    // R2: request without strobe stays pending, appears at strobe
    step(0, 0, 3'b010, 0, 0);
    chk("R2 no strobe", int'(regRdata[6:4]), 0);
    step(0, 0, 3'b000, 1, 0);
    chk("R2 strobe sets t0", int'(regRdata[6:4]), 2);
    // R3 sticky with enables off; R5 masked
    step();
    chk("R3 sticky", int'(regRdata[6:4]), 2);
    chk("R5 no gie no req", int'(intReq), 0);
    // R3 software clear
    step(1, 8'h00);
    chk("R3 sw clear", int'(regRdata), 0);
    // R4 same-cycle set vs clear
    step(1, 8'h0E, 3'b001, 1, 0);
    chk("R4 set wins", int'(regRdata), 8'h1E);
    // R8 ack without request (gie=0)
    step(0, 0, 0, 0, 1);
    chk("R8 no pulse", int'(ackPulse), 0);
    chk("R8 reg unchanged", int'(regRdata), 8'h1E);
    // R1 bit 7 never reads set
    step(1, 8'hFF);
    chk("R1 bit7 zero", int'(regRdata), 8'h7F);
    // R6 priority: all pending, ext first
    chk("R5 req on", int'(intReq), 1);
    @(negedge clk); intAck = 1;
    @(negedge clk); intAck = 0;
    chk("R7 pulse", int'(ackPulse), 1);
    chk("R6 vec ext", int'(vecOut), 8'h04);
    chk("R7 cleared", int'(regRdata), 8'h6E);
    @(negedge clk);
    chk("R7 single pulse", int'(ackPulse), 0);
    // R7 ack clear beats write of gie; flag re-set by strobe in same cycle
    step(1, 8'h6F);
    step(1, 8'h6F, 3'b010, 1, 1);
    chk("R7 gie cleared over write", int'(regRdata[0]), 0);
    chk("R6 vec t0", int'(vecOut), 8'h08);
    chk("R4 set over service", int'(regRdata[6:4]), 3'b110);
    // R6 timer 1 vector when t0 disabled
    step(1, 8'h49);
    step(0, 0, 0, 0, 1);
    chk("R6 vec t1", int'(vecOut), 8'h0C);
    // random mix, checked cycle by cycle against the model
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      regWe = ($urandom % 8) == 0;
      regWdata = 8'($urandom);
      reqRaw = 3'($urandom) & 3'($urandom);
      phaseStb = ($urandom % 4) == 0;
      intAck = ($urandom % 3) == 0;
    end
    @(negedge clk);
    regWe = 0; reqRaw = 0; phaseStb = 0; intAck = 0;
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule